// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block keeps the bookkeeping of an eight-deep circular register stack for a floating-point unit. Operands are named relative to a rotating top pointer: relative slot i lives in physical entry (top + i) modulo 8. The block holds the 64-bit payload of every entry as an opaque value, a 2-bit occupancy tag per entry, a 16-bit status word that always carries the current top pointer, and a 16-bit control word. It performs no arithmetic and decodes no instructions; a decoder ahead of it issues one command per clock on a one-hot command vector, together with a relative slot number, a data word and a condition-flag selector.

The supported commands are push, pop, exchange, free, control-word load, tag-word load, status snapshot, exception clear, initialize and condition-flag write. Push and pop detect stack overflow and underflow through the tags and report them as a stack fault in the status word instead of corrupting the stack. A separate read port translates a relative slot to its physical entry and returns the stored payload.

Top module: `fpstk_ctrl`

## Requirements
- R1: For a relative slot i on rd_idx_i, rd_phys_o equals (top + i) modulo 8 and rd_data_o returns the payload held in that physical entry.
- R2: sw_o bits 13:11 always equal top_o; a status-snapshot command (cmd_i bit 6) loads snap_o with the value of sw_o at that clock, top included.
- R3: A flag-write command (cmd_i bit 9) writes cc_val_i into the status bit chosen by cc_sel_i (0 selects bit 8, 1 selects bit 9, 2 selects bit 10, 3 selects bit 14) and leaves every other status bit unchanged.
- R4: tag_word_o bits 2k+1:2k hold the tag of physical entry k (00 = valid, 11 = empty); a tag-load command (cmd_i bit 5) unpacks wdata_i[15:0] into the tags with the same layout.
- R5: A control-load command (cmd_i bit 4) stores wdata_i[15:0] in cw_o; round_o follows cw_o bits 11:10 and exmask_o follows cw_o bits 5:0, while bits 9:8 are kept but drive neither.
- R6: A free command (cmd_i bit 3) marks the entry addressed by relative slot idx_i empty and leaves its payload and the top pointer unchanged.
- R7: An exchange command (cmd_i bit 2) swaps payload and tag of relative slot 0 with those of relative slot idx_i.
- R8: A push command (cmd_i bit 0) whose target, the entry at relative slot 7, is empty decrements top modulo 8, stores wdata_i in the new slot 0 and marks it valid.
- R9: A pop command (cmd_i bit 1) on a valid slot 0 marks that entry empty and increments top modulo 8.
- R10: A push onto a non-empty target sets status bits 6, 0 and 9; a pop of an empty slot 0 sets status bits 6 and 0 and clears bit 9; in both cases top, tags and payloads are unchanged.
- R11: Reset and the initialize command (cmd_i bit 8) set cw_o to 0x037F, the status word and top to zero and every tag to empty.
- R12: An exception-clear command (cmd_i bit 7) zeroes status bits 7:0 and keeps bits 15:8.
- R13: A command takes effect at the next rising clock edge; a cmd_i with more than one bit set is ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 10 | One-hot command vector |
| idx_i | input | 3 | Relative slot operand for free and exchange |
| rd_idx_i | input | 3 | Relative slot for the read port |
| wdata_i | input | 64 | Push payload; low 16 bits feed control and tag loads |
| cc_sel_i | input | 2 | Condition flag selector for flag writes |
| cc_val_i | input | 1 | Value written by a flag write |
| top_o | output | 3 | Current top pointer |
| sw_o | output | 16 | Status word with top in bits 13:11 |
| snap_o | output | 16 | Last captured status word |
| cw_o | output | 16 | Control word |
| round_o | output | 2 | Rounding mode field |
| exmask_o | output | 6 | Exception mask field |
| tag_word_o | output | 16 | Packed tag word |
| rd_phys_o | output | 3 | Physical entry of rd_idx_i |
| rd_data_o | output | 64 | Payload of rd_idx_i |

## Verification
A wrong top pointer shows one clock after the offending command, both in sw_o bits 13:11 and in rd_phys_o, and it shifts every later read so the error keeps propagating. A misplaced or stale tag appears at once in tag_word_o and, later, as a spurious or missing stack fault on the next push or pop that touches the entry. Payload errors stay hidden until the affected slot is read back, so the bench reads the exchanged, freed and pushed slots directly after each such command.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
   localparam int NCMD = 10;

   // command vector bit positions
   localparam int C_PUSH  = 0;
   localparam int C_POP   = 1;
   localparam int C_XCHG  = 2;
   localparam int C_FREE  = 3;
   localparam int C_LDCW  = 4;
   localparam int C_LDTAG = 5;
   localparam int C_STSW  = 6;
   localparam int C_CLREX = 7;
   localparam int C_INIT  = 8;
   localparam int C_SETCC = 9;

   localparam logic [1:0]  TAG_VALID = 2'b00;
   localparam logic [1:0]  TAG_EMPTY = 2'b11;
   localparam logic [15:0] CW_INIT   = 16'h037F;

   // status word bit positions
   localparam int SW_IE  = 0;
   localparam int SW_SF  = 6;
   localparam int SW_CC0 = 8;
   localparam int SW_CC1 = 9;
   localparam int SW_CC2 = 10;
   localparam int SW_TOP = 11;
   localparam int SW_CC3 = 14;
endpackage

// File: rtl/fpstk_map.sv
module fpstk_map #(
   parameter int NREG  = 8,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic [IDX_W-1:0] top_i,
   input  logic [IDX_W-1:0] rel_i,
   output logic [IDX_W-1:0] phys_o
);
   localparam bit POW2 = (NREG == (1 << IDX_W));

   generate
      if (POW2) begin : g_wrap
         // natural wrap of the adder width gives the modulo
         assign phys_o = top_i + rel_i;
      end else begin : g_mod
         logic [IDX_W:0] sum;
         assign sum    = {1'b0, top_i} + {1'b0, rel_i};
         assign phys_o = (sum >= (IDX_W+1)'(NREG)) ? IDX_W'(sum - (IDX_W+1)'(NREG))
                                                   : sum[IDX_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/fpstk_tags.sv
module fpstk_tags
   import fpstk_pkg::*;
#(
   parameter int NREG  = 8,
   localparam int IDX_W = $clog2(NREG),
   localparam int TW    = 2 * NREG
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             init_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [1:0]       wr_val_i,
   input  logic             swp_en_i,
   input  logic [IDX_W-1:0] swp_a_i,
   input  logic [IDX_W-1:0] swp_b_i,
   input  logic             ld_en_i,
   input  logic [TW-1:0]    ld_word_i,
   output logic [TW-1:0]    word_o
);
   logic [1:0] tag_q [NREG];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < NREG; k++) tag_q[k] <= TAG_EMPTY;
      end else if (init_i) begin
         for (int k = 0; k < NREG; k++) tag_q[k] <= TAG_EMPTY;
      end else if (ld_en_i) begin
         for (int k = 0; k < NREG; k++) tag_q[k] <= ld_word_i[2*k +: 2];
      end else if (swp_en_i) begin
         tag_q[swp_a_i] <= tag_q[swp_b_i];
         tag_q[swp_b_i] <= tag_q[swp_a_i];
      end else if (wr_en_i) begin
         tag_q[wr_idx_i] <= wr_val_i;
      end
   end

   generate
      for (genvar g = 0; g < NREG; g++) begin : g_pack
         assign word_o[2*g +: 2] = tag_q[g];
      end
   endgenerate

   // R4: a loaded tag word reads back unchanged
   p_tag_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_en_i && !init_i) |=> (word_o == $past(ld_word_i)))
      else $error("tag word load mismatch");
endmodule

// File: rtl/fpstk_data.sv
module fpstk_data #(
   parameter int NREG   = 8,
   parameter int DATA_W = 64,
   localparam int IDX_W = $clog2(NREG)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              swp_en_i,
   input  logic [IDX_W-1:0]  swp_a_i,
   input  logic [IDX_W-1:0]  swp_b_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [DATA_W-1:0] rd_data_o
);
   logic [DATA_W-1:0] mem_q [NREG];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int k = 0; k < NREG; k++) mem_q[k] <= '0;
      end else if (swp_en_i) begin
         mem_q[swp_a_i] <= mem_q[swp_b_i];
         mem_q[swp_b_i] <= mem_q[swp_a_i];
      end else if (wr_en_i) begin
         mem_q[wr_idx_i] <= wr_data_i;
      end
   end

   assign rd_data_o = mem_q[rd_idx_i];

   // R8: a written payload is present one clock later
   p_data_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !swp_en_i) |=> (mem_q[$past(wr_idx_i)] == $past(wr_data_i)))
      else $error("payload write lost");
endmodule

// File: rtl/fpstk_ctrl.sv
module fpstk_ctrl
   import fpstk_pkg::*;
#(
   parameter int NREG   = 8,
   parameter int DATA_W = 64,
   localparam int IDX_W = $clog2(NREG),
   localparam int TW    = 2 * NREG
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NCMD-1:0]   cmd_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [1:0]        cc_sel_i,
   input  logic              cc_val_i,
   output logic [IDX_W-1:0]  top_o,
   output logic [15:0]       sw_o,
   output logic [15:0]       snap_o,
   output logic [15:0]       cw_o,
   output logic [1:0]        round_o,
   output logic [5:0]        exmask_o,
   output logic [TW-1:0]     tag_word_o,
   output logic [IDX_W-1:0]  rd_phys_o,
   output logic [DATA_W-1:0] rd_data_o
);
   // elaboration checks
   generate
      if (NREG != 8) begin : g_bad_nreg
         $error("status word top field holds exactly 8 entries");
      end
      if (DATA_W < 16) begin : g_bad_width
         $error("payload must carry at least the 16-bit load words");
      end
   endgenerate

   logic [IDX_W-1:0] top_q;
   logic [15:0]      sw_q;     // bits 13:11 held at zero, top inserted on output
   logic [15:0]      cw_q;
   logic [15:0]      snap_q;

   // command qualification
   logic acc;
   logic c_push, c_pop, c_xchg, c_free, c_ldcw, c_ldtag, c_stsw, c_clrex, c_init, c_setcc;
   assign acc     = $onehot(cmd_i);
   assign c_push  = acc & cmd_i[C_PUSH];
   assign c_pop   = acc & cmd_i[C_POP];
   assign c_xchg  = acc & cmd_i[C_XCHG];
   assign c_free  = acc & cmd_i[C_FREE];
   assign c_ldcw  = acc & cmd_i[C_LDCW];
   assign c_ldtag = acc & cmd_i[C_LDTAG];
   assign c_stsw  = acc & cmd_i[C_STSW];
   assign c_clrex = acc & cmd_i[C_CLREX];
   assign c_init  = acc & cmd_i[C_INIT];
   assign c_setcc = acc & cmd_i[C_SETCC];

   // relative to physical translation
   logic [IDX_W-1:0] cmd_phys, push_phys;

   fpstk_map #(.NREG(NREG)) i_map_cmd (
      .top_i (top_q), .rel_i (idx_i), .phys_o (cmd_phys));
   fpstk_map #(.NREG(NREG)) i_map_rd (
      .top_i (top_q), .rel_i (rd_idx_i), .phys_o (rd_phys_o));
   fpstk_map #(.NREG(NREG)) i_map_push (
      .top_i (top_q), .rel_i (IDX_W'(NREG-1)), .phys_o (push_phys));

   // fault detection from the tags
   logic [1:0] tag_push, tag_top;
   logic push_ovf, push_ok, pop_unf, pop_ok;
   assign tag_push = tag_word_o[2*push_phys +: 2];
   assign tag_top  = tag_word_o[2*top_q +: 2];
   assign push_ovf = c_push & (tag_push != TAG_EMPTY);
   assign push_ok  = c_push & ~push_ovf;
   assign pop_unf  = c_pop & (tag_top == TAG_EMPTY);
   assign pop_ok   = c_pop & ~pop_unf;

   // tag storage
   logic             tg_wr;
   logic [IDX_W-1:0] tg_idx;
   logic [1:0]       tg_val;
   assign tg_wr  = push_ok | pop_ok | c_free;
   assign tg_idx = push_ok ? push_phys : (pop_ok ? top_q : cmd_phys);
   assign tg_val = push_ok ? TAG_VALID : TAG_EMPTY;

   fpstk_tags #(.NREG(NREG)) i_tags (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .init_i    (c_init),
      .wr_en_i   (tg_wr),
      .wr_idx_i  (tg_idx),
      .wr_val_i  (tg_val),
      .swp_en_i  (c_xchg),
      .swp_a_i   (top_q),
      .swp_b_i   (cmd_phys),
      .ld_en_i   (c_ldtag),
      .ld_word_i (wdata_i[TW-1:0]),
      .word_o    (tag_word_o)
   );

   // payload storage
   fpstk_data #(.NREG(NREG), .DATA_W(DATA_W)) i_data (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (push_ok),
      .wr_idx_i  (push_phys),
      .wr_data_i (wdata_i),
      .swp_en_i  (c_xchg),
      .swp_a_i   (top_q),
      .swp_b_i   (cmd_phys),
      .rd_idx_i  (rd_phys_o),
      .rd_data_o (rd_data_o)
   );

   // top pointer
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      top_q <= '0;
      else if (c_init)  top_q <= '0;
      else if (push_ok) top_q <= top_q - 1'b1;
      else if (pop_ok)  top_q <= top_q + 1'b1;
   end

   // status word
   logic [15:0] sw_nxt;
   always_comb begin
      sw_nxt = sw_q;
      if (c_init) begin
         sw_nxt = '0;
      end else if (push_ovf) begin
         sw_nxt[SW_SF]  = 1'b1;
         sw_nxt[SW_IE]  = 1'b1;
         sw_nxt[SW_CC1] = 1'b1;
      end else if (pop_unf) begin
         sw_nxt[SW_SF]  = 1'b1;
         sw_nxt[SW_IE]  = 1'b1;
         sw_nxt[SW_CC1] = 1'b0;
      end else if (c_clrex) begin
         sw_nxt[7:0] = '0;
      end else if (c_setcc) begin
         unique case (cc_sel_i)
            2'd0: sw_nxt[SW_CC0] = cc_val_i;
            2'd1: sw_nxt[SW_CC1] = cc_val_i;
            2'd2: sw_nxt[SW_CC2] = cc_val_i;
            2'd3: sw_nxt[SW_CC3] = cc_val_i;
         endcase
      end
      sw_nxt[SW_TOP +: 3] = '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sw_q <= '0;
      else         sw_q <= sw_nxt;
   end

   assign sw_o = {sw_q[15:14], top_q, sw_q[10:0]};

   // control word and status snapshot
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cw_q   <= CW_INIT;
         snap_q <= '0;
      end else begin
         if (c_init)      cw_q <= CW_INIT;
         else if (c_ldcw) cw_q <= wdata_i[15:0];
         if (c_stsw)      snap_q <= sw_o;
      end
   end

   assign cw_o     = cw_q;
   assign round_o  = cw_q[11:10];
   assign exmask_o = cw_q[5:0];
   assign snap_o   = snap_q;
   assign top_o    = top_q;

   // R2: snapshot carries the top pointer of the capture clock
   p_snap_top_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_stsw |=> (snap_o[13:11] == $past(top_q)))
      else $error("snapshot top mismatch");

   // R6: free never moves the top pointer
   p_free_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_free |=> (top_q == $past(top_q)))
      else $error("free moved top");

   // R8: good push decrements top
   p_push_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_ok |=> (top_q == IDX_W'($past(top_q) - 1'b1)))
      else $error("push top step wrong");

   // R9: good pop increments top
   p_pop_top_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_ok |=> (top_q == IDX_W'($past(top_q) + 1'b1)))
      else $error("pop top step wrong");

   // R10: overflow flags and frozen stack
   p_push_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      push_ovf |=> (sw_o[6] && sw_o[0] && sw_o[9] && $stable(top_q) && $stable(tag_word_o)))
      else $error("overflow not reported");

   // R10: underflow flags and frozen stack
   p_pop_fault_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pop_unf |=> (sw_o[6] && sw_o[0] && !sw_o[9] && $stable(top_q) && $stable(tag_word_o)))
      else $error("underflow not reported");

   // R12: exception clear keeps the upper byte
   p_clrex_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      c_clrex |=> ((sw_o[7:0] == 8'h00) && (sw_o[15:8] == $past(sw_o[15:8]))))
      else $error("exception clear wrong");

   // R13: multi-hot commands change nothing
   p_multi_ignored_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$onehot0(cmd_i) |=> ($stable(top_q) && $stable(tag_word_o) && $stable(sw_o) && $stable(cw_o)))
      else $error("multi-hot command took effect");
endmodule

// File: tb/test_fpstk_ctrl.sv
module test_fpstk_ctrl;
   localparam int CLK_PERIOD = 10;

   // command encodings (bit positions from the requirements)
   localparam logic [9:0] K_PUSH  = 10'h001;
   localparam logic [9:0] K_POP   = 10'h002;
   localparam logic [9:0] K_XCHG  = 10'h004;
   localparam logic [9:0] K_FREE  = 10'h008;
   localparam logic [9:0] K_LDCW  = 10'h010;
   localparam logic [9:0] K_LDTAG = 10'h020;
   localparam logic [9:0] K_STSW  = 10'h040;
   localparam logic [9:0] K_CLREX = 10'h080;
   localparam logic [9:0] K_INIT  = 10'h100;
   localparam logic [9:0] K_SETCC = 10'h200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  cmd = '0;
   logic [2:0]  idx = '0;
   logic [2:0]  rd_idx = '0;
   logic [63:0] wdata = '0;
   logic [1:0]  cc_sel = '0;
   logic        cc_val = 1'b0;
   logic [2:0]  top;
   logic [15:0] sw, snap, cw, tagw;
   logic [1:0]  rnd;
   logic [5:0]  exm;
   logic [2:0]  rd_phys;
   logic [63:0] rd_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpstk_ctrl i_fpstk_ctrl (
      .clk_i (clk), .rst_ni (rst_n), .cmd_i (cmd), .idx_i (idx),
      .rd_idx_i (rd_idx), .wdata_i (wdata), .cc_sel_i (cc_sel), .cc_val_i (cc_val),
      .top_o (top), .sw_o (sw), .snap_o (snap), .cw_o (cw), .round_o (rnd),
      .exmask_o (exm), .tag_word_o (tagw), .rd_phys_o (rd_phys), .rd_data_o (rd_data));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one command for one clock; returns at the following falling edge
   task automatic issue(input logic [9:0] c, input logic [2:0] i, input logic [63:0] d,
                        input logic [1:0] s, input logic v);
      @(negedge clk);
      cmd = c; idx = i; wdata = d; cc_sel = s; cc_val = v;
      @(negedge clk);
      cmd = '0;
   endtask

   // vector layout: cmd[71:62] idx[61:59] arg[58:43] sel[42:41] val[40] pad[39:35]
   //                top[34:32] tagword[31:16] status[15:0]
   localparam int NVEC = 20;
   localparam logic [71:0] VEC [NVEC] = '{
      {K_PUSH , 3'd0, 16'h1111, 2'd0, 1'b0, 5'd0, 3'd7, 16'h3FFF, 16'h3800}, // R8 R2 R4
      {K_PUSH , 3'd0, 16'h2222, 2'd0, 1'b0, 5'd0, 3'd6, 16'h0FFF, 16'h3000}, // R8
      {K_PUSH , 3'd0, 16'h3333, 2'd0, 1'b0, 5'd0, 3'd5, 16'h03FF, 16'h2800}, // R8
      {K_POP  , 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd6, 16'h0FFF, 16'h3000}, // R9
      {K_POP  , 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd7, 16'h3FFF, 16'h3800}, // R9
      {K_POP  , 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'hFFFF, 16'h0000}, // R9 wrap
      {K_POP  , 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'hFFFF, 16'h0041}, // R10 underflow
      {K_CLREX, 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'hFFFF, 16'h0000}, // R12
      {K_SETCC, 3'd0, 16'h0000, 2'd3, 1'b1, 5'd0, 3'd0, 16'hFFFF, 16'h4000}, // R3 bit 14
      {K_SETCC, 3'd0, 16'h0000, 2'd0, 1'b1, 5'd0, 3'd0, 16'hFFFF, 16'h4100}, // R3 bit 8
      {K_SETCC, 3'd0, 16'h0000, 2'd3, 1'b0, 5'd0, 3'd0, 16'hFFFF, 16'h0100}, // R3 clear
      {K_LDTAG, 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'h0000, 16'h0100}, // R4
      {K_PUSH , 3'd0, 16'h4444, 2'd0, 1'b0, 5'd0, 3'd0, 16'h0000, 16'h0341}, // R10 overflow
      {K_CLREX, 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'h0000, 16'h0300}, // R12
      {K_INIT , 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'hFFFF, 16'h0000}, // R11
      {K_LDTAG, 3'd0, 16'h5555, 2'd0, 1'b0, 5'd0, 3'd0, 16'h5555, 16'h0000}, // R4
      {K_FREE , 3'd3, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'h55D5, 16'h0000}, // R6
      {K_SETCC, 3'd0, 16'h0000, 2'd2, 1'b1, 5'd0, 3'd0, 16'h55D5, 16'h0400}, // R3 bit 10
      {K_SETCC, 3'd0, 16'h0000, 2'd1, 1'b1, 5'd0, 3'd0, 16'h55D5, 16'h0600}, // R3 bit 9
      {K_INIT , 3'd0, 16'h0000, 2'd0, 1'b0, 5'd0, 3'd0, 16'hFFFF, 16'h0000}  // R11
   };

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11 reset top", 64'(top), 64'd0);
      chk("R11 reset tags", 64'(tagw), 64'hFFFF);
      chk("R11 reset status", 64'(sw), 64'h0);
      chk("R11 reset control", 64'(cw), 64'h037F);
      rst_n = 1'b1;
      @(negedge clk);

      for (int n = 0; n < NVEC; n++) begin
         logic [71:0] v;
         v = VEC[n];
         issue(v[71:62], v[61:59], {4{v[58:43]}}, v[42:41], v[40]);
         chk($sformatf("row %0d top", n), 64'(top), 64'(v[34:32]));
         chk($sformatf("row %0d tagword", n), 64'(tagw), 64'(v[31:16]));
         chk($sformatf("row %0d status", n), 64'(sw), 64'(v[15:0]));
      end

      // R1 / R8: three pushes, then read through relative slots
      issue(K_PUSH, 3'd0, {4{16'hAAAA}}, 2'd0, 1'b0);
      issue(K_PUSH, 3'd0, {4{16'hBBBB}}, 2'd0, 1'b0);
      issue(K_PUSH, 3'd0, {4{16'hCCCC}}, 2'd0, 1'b0);
      chk("R8 top after 3 pushes", 64'(top), 64'd5);
      rd_idx = 3'd2; #1;
      chk("R1 phys of slot 2", 64'(rd_phys), 64'd7);
      chk("R1 data of slot 2", rd_data, {4{16'hAAAA}});
      rd_idx = 3'd4; #1;
      chk("R1 phys wrap of slot 4", 64'(rd_phys), 64'd1);
      rd_idx = 3'd0; #1;
      chk("R8 data of slot 0", rd_data, {4{16'hCCCC}});

      // R7: exchange slot 0 with slot 2
      issue(K_XCHG, 3'd2, '0, 2'd0, 1'b0);
      rd_idx = 3'd0; #1;
      chk("R7 slot 0 after exchange", rd_data, {4{16'hAAAA}});
      rd_idx = 3'd2; #1;
      chk("R7 slot 2 after exchange", rd_data, {4{16'hCCCC}});
      chk("R7 top after exchange", 64'(top), 64'd5);

      // R6: free slot 1 (physical 6)
      issue(K_FREE, 3'd1, '0, 2'd0, 1'b0);
      chk("R6 tagword after free", 64'(tagw), 64'h33FF);
      chk("R6 top after free", 64'(top), 64'd5);
      rd_idx = 3'd1; #1;
      chk("R6 payload kept after free", rd_data, {4{16'hBBBB}});

      // R7: exchange moves tags too
      issue(K_XCHG, 3'd1, '0, 2'd0, 1'b0);
      chk("R7 tag swap", 64'(tagw), 64'h0FFF);

      // R10: slot 0 now empty, pop must fault
      issue(K_POP, 3'd0, '0, 2'd0, 1'b0);
      chk("R10 underflow status", 64'(sw), 64'h2841);
      chk("R10 underflow top", 64'(top), 64'd5);
      issue(K_CLREX, 3'd0, '0, 2'd0, 1'b0);
      chk("R12 clear with top", 64'(sw), 64'h2800);

      // R13: multi-hot command is ignored
      issue(K_PUSH | K_POP, 3'd0, {4{16'h9999}}, 2'd0, 1'b0);
      chk("R13 multi-hot top", 64'(top), 64'd5);
      chk("R13 multi-hot tags", 64'(tagw), 64'h0FFF);
      chk("R13 multi-hot status", 64'(sw), 64'h2800);

      // R5: control word fields
      issue(K_LDCW, 3'd0, 64'h0C3A, 2'd0, 1'b0);
      chk("R5 control word", 64'(cw), 64'h0C3A);
      chk("R5 rounding field", 64'(rnd), 64'd3);
      chk("R5 mask field", 64'(exm), 64'h3A);
      issue(K_LDCW, 3'd0, 64'h0300, 2'd0, 1'b0);
      chk("R5 precision stored", 64'(cw), 64'h0300);
      chk("R5 precision not in rounding", 64'(rnd), 64'd0);
      chk("R5 precision not in mask", 64'(exm), 64'h00);

      // R2: snapshot includes top
      issue(K_SETCC, 3'd0, '0, 2'd3, 1'b1);
      issue(K_STSW, 3'd0, '0, 2'd0, 1'b0);
      chk("R2 snapshot", 64'(snap), 64'h6800);
      chk("R2 status top field", 64'(sw[13:11]), 64'(top));

      // R11: reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R11 reset again top", 64'(top), 64'd0);
      chk("R11 reset again tags", 64'(tagw), 64'hFFFF);
      chk("R11 reset again control", 64'(cw), 64'h037F);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule